// File: doc/BRIEF.md
# Banked Working-Register RAM with Hardware Stack

This block is the 128-byte on-chip data store of a small 8-bit controller. The lowest 32 bytes hold four banks of eight working registers, and the hardware stack also grows through that area. Above them sits a 16-byte window whose 128 bits can each be reached one at a time. The remaining bytes up to the top of the store are plain scratch space. A status byte lives beside the array. Two of its bits pick which bank of working registers a register-number access lands in.

The block takes five kinds of request, each on its own set of pins. They are a stack push, a stack pop, a direct byte access, a register-number access and a single-bit access. A single-bit access can target either the bit window or the status byte. At most one request is served in any cycle, chosen by fixed priority. Any other request raised in that cycle is dropped and flagged. Reads return their byte one cycle later with a valid strobe. The stack pointer and the status byte are always visible on output ports.

Top module: `iram_bank_stack`

## Requirements
- R1: After reset the stack pointer reads 0x07, the status byte reads 0x00 (so bank 0 is active), and both the read strobe and the error flag are low.
- R2: A direct byte write stores the data at the given address (0x00 to 0x7F). A direct byte read returns that byte on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R3: A register-number access to register n (0 to 7) touches byte address bank*8 + n, where bank is status bits [4:3] and bit 4 is the high bit.
- R4: A bit access with `bit_to_status` low and bit number b (0 to 127) touches byte 0x20 + b[6:3], bit b[2:0]. A bit write changes only that bit, in one cycle. A bit read returns the bit in `rd_data[0]`, with the upper bits zero.
- R5: A bit access with `bit_to_status` high reads or writes status bit `bit_addr[2:0]`. Setting or clearing bits 3 and 4 changes the active bank for later register-number accesses. No other request changes the status byte.
- R6: A push first adds one to the stack pointer and then writes the pushed byte at the new pointer value. The first push after reset therefore lands at 0x08.
- R7: A pop returns the byte at the current pointer on `rd_data` in the next cycle. It then lowers the pointer by one.
- R8: The stack pointer is 8 bits wide and wraps modulo 256, so a pop at 0x00 leaves 0xFF and a push at 0xFF leaves 0x00. The stack uses the low 7 pointer bits as the byte address. The pointer keeps its value in cycles with neither a push nor a pop.
- R9: When several requests arrive in one cycle, only the highest in the order push, pop, byte, register, bit is served. The others have no effect, and `req_err` is high in the next cycle. With one request or none, `req_err` is low in the next cycle.
- R10: `rd_valid` is high only in the cycle after a served read (pop, byte read, register read or bit read). It is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stk_push | input | 1 | Push request |
| stk_wdata | input | 8 | Byte to push |
| stk_pop | input | 1 | Pop request |
| byte_en | input | 1 | Direct byte request |
| byte_we | input | 1 | Direct byte request is a write |
| byte_addr | input | 7 | Direct byte address |
| byte_wdata | input | 8 | Direct byte write data |
| reg_en | input | 1 | Register-number request |
| reg_we | input | 1 | Register-number request is a write |
| reg_idx | input | 3 | Register number within the active bank |
| reg_wdata | input | 8 | Register write data |
| bit_en | input | 1 | Single-bit request |
| bit_we | input | 1 | Single-bit request is a write |
| bit_val | input | 1 | Value written by a single-bit write |
| bit_to_status | input | 1 | Single-bit request targets the status byte |
| bit_addr | input | 7 | Bit number in the window, or status bit in [2:0] |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| req_err | output | 1 | A request of the previous cycle was dropped |
| sp_o | output | 8 | Current stack pointer |
| status_o | output | 8 | Current status byte |

## Verification
Every result of this block comes from a register. The read byte, its strobe, the error flag, the pointer and the status byte all change at the first rising edge that samples a request, so each one is due exactly one cycle later. The bench drives each request on a falling edge and samples all outputs on the next falling edge. Expected read bytes go into a queue. The monitor, also on falling edges, pops an entry for every strobe it sees, so a late, early or missing result shows up as a miscompare. Pointer, status and error checks are made in the same cycle as the read comparison.

// File: rtl/iram_pkg.sv
package iram_pkg;
   // request slots; a lower index wins arbitration
   localparam int unsigned NUM_REQ = 5;
   localparam int unsigned Q_PUSH  = 0;
   localparam int unsigned Q_POP   = 1;
   localparam int unsigned Q_BYTE  = 2;
   localparam int unsigned Q_REG   = 3;
   localparam int unsigned Q_BIT   = 4;

   typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/iram_arb.sv
module iram_arb
   import iram_pkg::*;
#(
   parameter int unsigned N = NUM_REQ
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         clash
);
   if (N < 2) begin : g_bad_n
      $error("iram_arb: at least two request slots are needed");
   end

   // seen[i] is high when any request of higher priority than slot i is present
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   // more than one bit set: clearing the lowest set bit leaves something
   assign clash = |(req & (req - N'(1)));
endmodule

// File: rtl/iram_map.sv
module iram_map
   import iram_pkg::*;
#(
   parameter int unsigned AW       = 7,
   parameter int unsigned RIW      = 3,
   parameter int unsigned BKW      = 2,
   parameter int unsigned BPW      = 3,
   parameter int unsigned BAW      = 7,
   parameter int unsigned SPW      = 8,
   parameter int unsigned BIT_BASE = 32
) (
   input  req_vec_t        gnt,
   input  logic [AW-1:0]   byte_addr,
   input  logic [RIW-1:0]  reg_idx,
   input  logic [BKW-1:0]  bank,
   input  logic [BAW-1:0]  bit_addr,
   input  logic [SPW-1:0]  sp_cur,
   input  logic [SPW-1:0]  sp_inc,
   output logic [AW-1:0]   addr,
   output logic [BPW-1:0]  bit_pos
);
   if (BKW + RIW > AW) begin : g_bad_bank
      $error("iram_map: register banks exceed the address space");
   end
   if (SPW < AW) begin : g_bad_sp
      $error("iram_map: stack pointer narrower than the byte address");
   end

   logic [AW-1:0] reg_byte;
   logic [AW-1:0] bit_byte;

   assign reg_byte = AW'({bank, reg_idx});
   assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr >> BPW);
   assign bit_pos  = bit_addr[BPW-1:0];

   always_comb begin
      addr = '0;
      if (gnt[Q_PUSH])      addr = sp_inc[AW-1:0];
      else if (gnt[Q_POP])  addr = sp_cur[AW-1:0];
      else if (gnt[Q_BYTE]) addr = byte_addr;
      else if (gnt[Q_REG])  addr = reg_byte;
      else if (gnt[Q_BIT])  addr = bit_byte;
   end
endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
   parameter int unsigned SPW      = 8,
   parameter int unsigned SP_RESET = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           inc,
   input  logic           dec,
   output logic [SPW-1:0] sp,
   output logic [SPW-1:0] sp_inc
);
   if (SP_RESET >= (1 << SPW)) begin : g_bad_rst
      $error("iram_sp: reset value does not fit the pointer");
   end

   assign sp_inc = sp + SPW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   sp <= SPW'(SP_RESET);
      else if (inc) sp <= sp_inc;
      else if (dec) sp <= sp - SPW'(1);
   end
endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack
   import iram_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned DEPTH     = 128,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_REGS = 8,
   parameter int unsigned BIT_BASE  = 32,
   parameter int unsigned BIT_BYTES = 16,
   parameter int unsigned BANK_LSB  = 3,
   parameter int unsigned SPW       = 8,
   parameter int unsigned SP_RESET  = 7,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned RIW      = $clog2(BANK_REGS),
   localparam int unsigned BKW      = $clog2(NUM_BANKS),
   localparam int unsigned BPW      = $clog2(DW),
   localparam int unsigned BAW      = $clog2(BIT_BYTES * DW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stk_push,
   input  logic [DW-1:0]   stk_wdata,
   input  logic            stk_pop,
   input  logic            byte_en,
   input  logic            byte_we,
   input  logic [AW-1:0]   byte_addr,
   input  logic [DW-1:0]   byte_wdata,
   input  logic            reg_en,
   input  logic            reg_we,
   input  logic [RIW-1:0]  reg_idx,
   input  logic [DW-1:0]   reg_wdata,
   input  logic            bit_en,
   input  logic            bit_we,
   input  logic            bit_val,
   input  logic            bit_to_status,
   input  logic [BAW-1:0]  bit_addr,
   output logic [DW-1:0]   rd_data,
   output logic            rd_valid,
   output logic            req_err,
   output logic [SPW-1:0]  sp_o,
   output logic [DW-1:0]   status_o
);
   // ---------------- elaboration checks ----------------
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("iram_bank_stack: DEPTH must be a power of two");
   end
   if (BANK_REGS != (1 << RIW) || NUM_BANKS != (1 << BKW)) begin : g_bad_banks
      $error("iram_bank_stack: bank count and size must be powers of two");
   end
   if (NUM_BANKS * BANK_REGS > BIT_BASE) begin : g_bad_overlap
      $error("iram_bank_stack: register banks overlap the bit window");
   end
   if (BIT_BASE + BIT_BYTES > DEPTH) begin : g_bad_window
      $error("iram_bank_stack: bit window exceeds the array");
   end
   if (BANK_LSB + BKW > DW) begin : g_bad_field
      $error("iram_bank_stack: bank field outside the status byte");
   end
   if (DW != (1 << BPW) || BAW < BPW) begin : g_bad_dw
      $error("iram_bank_stack: data width must be a power of two");
   end

   // ---------------- arbitration ----------------
   req_vec_t req;
   req_vec_t gnt;
   logic     clash;

   always_comb begin
      req         = '0;
      req[Q_PUSH] = stk_push;
      req[Q_POP]  = stk_pop;
      req[Q_BYTE] = byte_en;
      req[Q_REG]  = reg_en;
      req[Q_BIT]  = bit_en;
   end

   iram_arb #(.N(NUM_REQ)) u_arb (
      .req   (req),
      .gnt   (gnt),
      .clash (clash)
   );

   // ---------------- stack pointer ----------------
   logic [SPW-1:0] sp_cur;
   logic [SPW-1:0] sp_inc;

   iram_sp #(.SPW(SPW), .SP_RESET(SP_RESET)) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (gnt[Q_PUSH]),
      .dec    (gnt[Q_POP]),
      .sp     (sp_cur),
      .sp_inc (sp_inc)
   );

   // ---------------- address resolution ----------------
   logic [DW-1:0]  status_q;
   logic [AW-1:0]  addr;
   logic [BPW-1:0] bit_pos;

   iram_map #(
      .AW(AW), .RIW(RIW), .BKW(BKW), .BPW(BPW), .BAW(BAW),
      .SPW(SPW), .BIT_BASE(BIT_BASE)
   ) u_map (
      .gnt       (gnt),
      .byte_addr (byte_addr),
      .reg_idx   (reg_idx),
      .bank      (status_q[BANK_LSB +: BKW]),
      .bit_addr  (bit_addr),
      .sp_cur    (sp_cur),
      .sp_inc    (sp_inc),
      .addr      (addr),
      .bit_pos   (bit_pos)
   );

   // ---------------- storage and data paths ----------------
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] mem_rd;
   logic [DW-1:0] bit_src;
   logic [DW-1:0] bit_merged;
   logic [DW-1:0] wr_data;
   logic          mem_we;
   logic          stat_we;
   logic          rd_fire;
   logic          bit_rd;

   assign mem_rd  = mem[addr];
   assign bit_src = bit_to_status ? status_q : mem_rd;

   always_comb begin
      bit_merged          = mem_rd;
      bit_merged[bit_pos] = bit_val;
   end

   assign mem_we  = gnt[Q_PUSH]
                  | (gnt[Q_BYTE] & byte_we)
                  | (gnt[Q_REG]  & reg_we)
                  | (gnt[Q_BIT]  & bit_we & ~bit_to_status);
   assign stat_we = gnt[Q_BIT] & bit_we & bit_to_status;
   assign bit_rd  = gnt[Q_BIT] & ~bit_we;
   assign rd_fire = gnt[Q_POP]
                  | (gnt[Q_BYTE] & ~byte_we)
                  | (gnt[Q_REG]  & ~reg_we)
                  | bit_rd;

   always_comb begin
      wr_data = bit_merged;
      if (gnt[Q_PUSH])      wr_data = stk_wdata;
      else if (gnt[Q_BYTE]) wr_data = byte_wdata;
      else if (gnt[Q_REG])  wr_data = reg_wdata;
   end

   always_ff @(posedge clk) begin
      if (mem_we) mem[addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         req_err  <= 1'b0;
      end else begin
         if (stat_we) status_q[bit_pos] <= bit_val;
         rd_valid <= rd_fire;
         req_err  <= clash;
         if (rd_fire) rd_data <= bit_rd ? DW'(bit_src[bit_pos]) : mem_rd;
      end
   end

   assign sp_o     = sp_cur;
   assign status_o = status_q;
endmodule

// File: rtl/iram_bank_stack_chk.sv
module iram_bank_stack_chk #(
   parameter int unsigned DW  = 8,
   parameter int unsigned SPW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           stk_push,
   input logic           stk_pop,
   input logic           byte_en,
   input logic           byte_we,
   input logic           reg_en,
   input logic           reg_we,
   input logic           bit_en,
   input logic           bit_we,
   input logic           bit_to_status,
   input logic           rd_valid,
   input logic           req_err,
   input logic [SPW-1:0] sp_o,
   input logic [DW-1:0]  status_o
);
   logic [4:0] reqs;
   logic       any_rd;

   assign reqs   = {stk_push, stk_pop, byte_en, reg_en, bit_en};
   assign any_rd = stk_pop | (byte_en & ~byte_we) | (reg_en & ~reg_we) | (bit_en & ~bit_we);

   assert_push_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |=> sp_o == SPW'($past(sp_o) + SPW'(1)));

   assert_pop_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_pop && !stk_push) |=> sp_o == SPW'($past(sp_o) - SPW'(1)));

   assert_sp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(stk_push || stk_pop) |=> $stable(sp_o));

   assert_clash_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(reqs) > 1) |=> req_err);

   assert_no_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(reqs) <= 1) |=> !req_err);

   assert_valid_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rd |=> !rd_valid);

   assert_status_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_en && bit_we && bit_to_status) |=> $stable(status_o));
endmodule

bind iram_bank_stack iram_bank_stack_chk #(.DW(DW), .SPW(SPW)) u_chk (.*);

// File: tb/test_iram_bank_stack.sv
`timescale 1ns/1ps
module test_iram_bank_stack;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stk_push = 0, stk_pop = 0;
   logic [7:0] stk_wdata = 0;
   logic       byte_en = 0, byte_we = 0;
   logic [6:0] byte_addr = 0;
   logic [7:0] byte_wdata = 0;
   logic       reg_en = 0, reg_we = 0;
   logic [2:0] reg_idx = 0;
   logic [7:0] reg_wdata = 0;
   logic       bit_en = 0, bit_we = 0, bit_val = 0, bit_to_status = 0;
   logic [6:0] bit_addr = 0;
   logic [7:0] rd_data;
   logic       rd_valid, req_err;
   logic [7:0] sp_o, status_o;

   always #4 clk = ~clk;   // 125 MHz

   iram_bank_stack i_iram_bank_stack (
      .clk(clk), .rst_n(rst_n),
      .stk_push(stk_push), .stk_wdata(stk_wdata), .stk_pop(stk_pop),
      .byte_en(byte_en), .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
      .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .bit_en(bit_en), .bit_we(bit_we), .bit_val(bit_val), .bit_to_status(bit_to_status),
      .bit_addr(bit_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .req_err(req_err),
      .sp_o(sp_o), .status_o(status_o)
   );

   int unsigned vectors = 0;
   int unsigned fails   = 0;

   // reference model, built from the requirements only
   bit [7:0] model [128];
   bit [7:0] msp  = 8'h07;
   bit [7:0] mst  = 8'h00;

   // scoreboard
   bit [7:0] exp_q [$];
   string    tag_q [$];

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: every read strobe consumes one expected byte
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            vectors++;
            fails++;
            $display("FAIL R10 unexpected read strobe: actual %0h expected none", rd_data);
         end else begin
            bit [7:0] e;
            string    t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "read data", rd_data, e);
         end
      end
   end

   // driver: applies one cycle of requests, updates the model, checks state
   task automatic step(string tag,
                       bit pu, bit [7:0] pd, bit po,
                       bit be, bit bwe, bit [6:0] ba, bit [7:0] bd,
                       bit re, bit rwe, bit [2:0] ri, bit [7:0] rdt,
                       bit te, bit twe, bit tv, bit ts, bit [6:0] ta);
      int       n;
      bit       rdx;
      bit [7:0] ex;
      bit [6:0] a;
      n   = int'(pu) + int'(po) + int'(be) + int'(re) + int'(te);
      rdx = 1'b0;
      ex  = 8'h00;
      if (pu) begin
         msp = msp + 8'd1;
         model[msp[6:0]] = pd;
      end else if (po) begin
         rdx = 1'b1; ex = model[msp[6:0]];
         msp = msp - 8'd1;
      end else if (be) begin
         if (bwe) model[ba] = bd; else begin rdx = 1'b1; ex = model[ba]; end
      end else if (re) begin
         a = {2'b00, mst[4:3], ri};
         if (rwe) model[a] = rdt; else begin rdx = 1'b1; ex = model[a]; end
      end else if (te) begin
         a = 7'h20 + {3'b000, ta[6:3]};
         if (twe) begin
            if (ts) mst[ta[2:0]] = tv; else model[a][ta[2:0]] = tv;
         end else begin
            rdx = 1'b1;
            ex  = {7'b0, ts ? mst[ta[2:0]] : model[a][ta[2:0]]};
         end
      end
      if (rdx) begin exp_q.push_back(ex); tag_q.push_back(tag); end
      stk_push = pu; stk_wdata = pd; stk_pop = po;
      byte_en = be; byte_we = bwe; byte_addr = ba; byte_wdata = bd;
      reg_en = re; reg_we = rwe; reg_idx = ri; reg_wdata = rdt;
      bit_en = te; bit_we = twe; bit_val = tv; bit_to_status = ts; bit_addr = ta;
      @(negedge clk);
      stk_push = 0; stk_pop = 0; byte_en = 0; reg_en = 0; bit_en = 0;
      chk(tag, "error flag (R9)", req_err, (n > 1) ? 1 : 0);
      chk(tag, "stack pointer", sp_o, msp);
      chk(tag, "status byte", status_o, mst);
      chk(tag, "read strobe (R10)", rd_valid, rdx);
   endtask

   task automatic wr(string t, bit [6:0] a, bit [7:0] d);
      step(t, 0, 0, 0, 1, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(string t, bit [6:0] a);
      step(t, 0, 0, 0, 1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic rwr(string t, bit [2:0] i, bit [7:0] d);
      step(t, 0, 0, 0, 0, 0, 0, 0, 1, 1, i, d, 0, 0, 0, 0, 0);
   endtask
   task automatic rrd(string t, bit [2:0] i);
      step(t, 0, 0, 0, 0, 0, 0, 0, 1, 0, i, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic bwr(string t, bit st, bit [6:0] b, bit v);
      step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, v, st, b);
   endtask
   task automatic brd(string t, bit st, bit [6:0] b);
      step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, st, b);
   endtask
   task automatic push(string t, bit [7:0] d);
      step(t, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic pop(string t);
      step(t, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #(8ns * 200000);
      vectors++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: state straight after reset
      chk("R1", "stack pointer", sp_o, 8'h07);
      chk("R1", "status byte", status_o, 8'h00);
      chk("R1", "read strobe", rd_valid, 0);
      chk("R1", "error flag", req_err, 0);

      // R2: fill the whole array, then read back corners and middle
      for (int i = 0; i < 128; i++) wr("R2", 7'(i), 8'(i * 3 + 1));
      wr("R2", 7'h45, 8'h55);
      wr("R2", 7'h7F, 8'hA5);
      rd("R2", 7'h45);
      rd("R2", 7'h7F);
      rd("R2", 7'h00);

      // R3: register numbers in bank 0, R5: bank switch through status bits
      rwr("R3", 3'd3, 8'h33);
      rd("R3", 7'h03);
      bwr("R5", 1'b1, 7'd3, 1'b1);           // bank 1
      rwr("R3", 3'd0, 8'h80);
      rd("R3", 7'h08);
      bwr("R5", 1'b1, 7'd4, 1'b1);           // bank 3
      rwr("R3", 3'd7, 8'hF7);
      rd("R3", 7'h1F);
      rrd("R3", 3'd7);
      brd("R5", 1'b1, 7'd4);
      bwr("R5", 1'b1, 7'd3, 1'b0);           // bank 2
      rrd("R3", 3'd1);                       // byte 0x11
      bwr("R5", 1'b1, 7'd4, 1'b0);           // back to bank 0

      // R4: single bits in the window
      wr("R4", 7'h2F, 8'h00);
      bwr("R4", 1'b0, 7'h7F, 1'b1);
      rd("R4", 7'h2F);                       // 0x80
      wr("R4", 7'h20, 8'hF0);
      bwr("R4", 1'b0, 7'h00, 1'b1);
      bwr("R4", 1'b0, 7'h05, 1'b0);
      rd("R4", 7'h20);                       // 0xD1
      brd("R4", 1'b0, 7'h04);
      brd("R4", 1'b0, 7'h03);
      bwr("R4", 1'b0, 7'h4A, 1'b1);          // byte 0x29 bit 2
      rd("R4", 7'h29);

      // R6 and R7: push then pop
      push("R6", 8'hAB);
      rd("R6", 7'h08);
      push("R6", 8'hCD);
      pop("R7");
      pop("R7");

      // R9: collisions
      wr("R9", 7'h40, 8'h12);
      step("R9", 1, 8'h5A, 0, 1, 1, 7'h40, 8'h99, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      rd("R9", 7'h40);
      rd("R9", 7'h08);
      step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3'd2, 8'h6C, 1, 1, 1, 1, 7'd3);
      rd("R9", 7'h02);
      step("R9", 1, 8'h3C, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 1, 1, 0, 7'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      // R8: wrap below zero and back
      while (msp != 8'hFF) pop("R8");
      push("R8", 8'h77);
      rd("R8", 7'h00);
      pop("R8");
      repeat (2) @(negedge clk);
      chk("R8", "stack pointer idle", sp_o, msp);

      // R10: no strobe on an idle cycle
      chk("R10", "read strobe idle", rd_valid, 0);
      chk("R10", "scoreboard drained", exp_q.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule